// File: doc/BRIEF.md
# Paper Tape Word Assembler with Bootstrap Loader

This block sits between a paper tape reader and a processor's in-out register. The reader presents one 8-hole line at a time with a single-cycle valid strobe. The block builds a 36-bit word from those lines. A one-cycle command input picks the job. Character reading takes a single line as it is. Word reading packs six data lines into a full word. Bootstrap loading reads a stream of words and uses them to fill memory and then start the processor.

In word reading, a line is used only when its marker hole (hole 8) is punched. Hole 7 is discarded, and holes 1 to 6 give six data bits per line. Bootstrap loading uses the same packing. It treats the words as alternating instruction and data words. A deposit instruction names the memory address for the data word that follows. A jump instruction ends the load and reports the start address. Any other instruction stops the load with an error flag.

The processor side sees the assembled word and a completion pulse. Memory sees a one-cycle write request with an address and data. The execution unit sees a one-cycle start pulse with an address. Reader mechanics and parity checking belong elsewhere.

Top module: `tape_word_loader`

## Requirements
- R1: After reset `word_out` is zero and `word_done`, `busy`, `mem_we`, `exec_start` and `boot_err` are all low.
- R2: Character read is started with `cmd_sel`=1. The next line with `line_valid` high is taken whatever its holes are. In the cycle after that line, `word_out` equals the 8 line bits in bits 7:0 with all higher bits zero, `word_done` is high for that one cycle, and `busy` is low.
- R3: Word read is started with `cmd_sel`=2. The data bits of a line are `line_data[5:0]`. The first accepted line lands in `word_out[35:30]`, and each later line lands in the next lower six bits. In the cycle after the sixth accepted line, `word_done` is high for one cycle and `busy` is low.
- R4: In word read and in bootstrap load, a line with `line_data[7]` (hole 8) low is skipped. It neither counts toward the six lines nor changes the word.
- R5: In word read and in bootstrap load, `line_data[6]` (hole 7) has no effect on the assembled word.
- R6: While `busy` is high, a nonzero `cmd_sel` is ignored and the current job continues. While `busy` is low, lines are ignored: `word_out` holds and `word_done` stays low.
- R7: Bootstrap load is started with `cmd_sel`=3. Its first word and every second word after that are instructions, with the opcode in bits 35:30 and the address in bits 11:0. For the deposit opcode 6'o32, the next word is written out: in the cycle after that data word completes, `mem_we` is high for one cycle with `mem_addr` = the address and `mem_wdata` = the word. Reading then continues with another instruction.
- R8: For the jump opcode 6'o60, in the cycle after the instruction word completes, `exec_start` is high for one cycle with `exec_addr` = the address, and `busy` is low.
- R9: Any other opcode in an instruction word sets `boot_err` and ends the load (`busy` low). No memory write and no start pulse follow. `boot_err` holds until the next bootstrap command clears it.
- R10: `word_done` pulses for one cycle after every completed word in bootstrap load as well, for instruction and data words alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sel | input | 2 | Job request: 0 none, 1 character, 2 word, 3 bootstrap |
| line_valid | input | 1 | One-cycle strobe for a new tape line |
| line_data | input | 8 | Tape line, bit i = hole i+1 |
| busy | output | 1 | A job is in progress |
| word_out | output | 36 | Last completed word |
| word_done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 36 | Memory write data |
| exec_start | output | 1 | One-cycle start-execution pulse |
| exec_addr | output | 12 | Start-execution address |
| boot_err | output | 1 | Bootstrap load stopped on an unknown instruction |

## Verification
The assertions assume three things about the inputs. `line_valid` is a single-cycle strobe. Commands come only while the block is idle, or are meant to be dropped. Lines reach the block only after a command has made it busy, apart from stray lines that are meant to be ignored. The bench drives each line and command for exactly one clock on the falling edge and then removes it. It starts each job only after the previous one has ended, except where it sends a command or a line on purpose to test that it is ignored. No two completions therefore fall on adjacent cycles, and that is what the pulse-width properties rely on.

// File: rtl/tape_ldr_pkg.sv
package tape_ldr_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_CHAR = 2'd1,
        CMD_WORD = 2'd2,
        CMD_BOOT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_CHAR = 2'd1,
        MODE_WORD = 2'd2,
        MODE_BOOT = 2'd3
    } mode_e;

endpackage

// File: rtl/tape_line_filter.sv
module tape_line_filter #(
    parameter int LINE_W   = 8,
    parameter int DATA_W   = 6,
    parameter int MARK_BIT = 7
) (
    input  logic              line_valid,
    input  logic [LINE_W-1:0] line_data,
    input  logic              enable,
    input  logic              pack_mode,
    output logic              take_char,
    output logic              take_pack,
    output logic [DATA_W-1:0] data_bits
);

    logic marked;

    // Marker hole decides whether a packed-mode line counts at all.
    assign marked    = line_data[MARK_BIT];
    assign take_char = line_valid && enable && !pack_mode;
    assign take_pack = line_valid && enable && pack_mode && marked;
    // Only the low data holes contribute; bits between DATA_W and MARK_BIT are dropped.
    assign data_bits = line_data[DATA_W-1:0];

endmodule

// File: rtl/tape_word_shifter.sv
module tape_word_shifter #(
    parameter int WORD_W = 36,
    parameter int DATA_W = 6,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_char,
    input  logic              take_pack,
    input  logic [DATA_W-1:0] data_bits,
    input  logic [LINE_W-1:0] char_bits,
    output logic              full_now,
    output logic [WORD_W-1:0] full_word,
    output logic [WORD_W-1:0] word_out,
    output logic              word_done
);

    localparam int LINES = WORD_W / DATA_W;
    localparam int CNT_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] out;
        logic              done;
    } sh_t;

    sh_t q, d;
    logic [WORD_W-1:0] shifted;

    assign shifted   = {q.shreg[WORD_W-DATA_W-1:0], data_bits};
    assign full_now  = take_pack && (q.cnt == LAST);
    assign full_word = shifted;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (take_char) begin
            d.out  = {{(WORD_W-LINE_W){1'b0}}, char_bits};
            d.done = 1'b1;
        end
        if (take_pack) begin
            if (q.cnt == LAST) begin
                d.out   = shifted;
                d.done  = 1'b1;
                d.cnt   = '0;
                d.shreg = '0;
            end else begin
                d.shreg = shifted;
                d.cnt   = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_out  = q.out;
    assign word_done = q.done;

endmodule

// File: rtl/tape_boot_seq.sv
module tape_boot_seq #(
    parameter int          WORD_W = 36,
    parameter int          ADDR_W = 12,
    parameter int          OP_W   = 6,
    parameter logic [5:0]  DEP_OP = 6'o32,
    parameter logic [5:0]  JMP_OP = 6'o60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_full,
    input  logic [WORD_W-1:0] word_bits,
    output logic              finish,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              exec_start,
    output logic [ADDR_W-1:0] exec_addr,
    output logic              boot_err
);

    typedef struct packed {
        logic              data_next;
        logic [ADDR_W-1:0] dep_addr;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic              exec;
        logic [ADDR_W-1:0] eaddr;
        logic              err;
    } bs_t;

    bs_t q, d;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] operand;

    assign opcode  = word_bits[WORD_W-1 -: OP_W];
    assign operand = word_bits[ADDR_W-1:0];

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.exec = 1'b0;
        finish = 1'b0;
        if (start) begin
            d.data_next = 1'b0;
            d.err       = 1'b0;
        end
        if (word_full) begin
            if (q.data_next) begin
                d.we        = 1'b1;
                d.waddr     = q.dep_addr;
                d.wdata     = word_bits;
                d.data_next = 1'b0;
            end else if (opcode == OP_W'(DEP_OP)) begin
                d.dep_addr  = operand;
                d.data_next = 1'b1;
            end else if (opcode == OP_W'(JMP_OP)) begin
                d.exec  = 1'b1;
                d.eaddr = operand;
                finish  = 1'b1;
            end else begin
                d.err  = 1'b1;
                finish = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we     = q.we;
    assign mem_addr   = q.waddr;
    assign mem_wdata  = q.wdata;
    assign exec_start = q.exec;
    assign exec_addr  = q.eaddr;
    assign boot_err   = q.err;

endmodule

// File: rtl/tape_word_loader.sv
module tape_word_loader #(
    parameter int         WORD_W   = 36,
    parameter int         LINE_W   = 8,
    parameter int         DATA_W   = 6,
    parameter int         MARK_BIT = 7,
    parameter int         ADDR_W   = 12,
    parameter int         OP_W     = 6,
    parameter logic [5:0] DEP_OP   = 6'o32,
    parameter logic [5:0] JMP_OP   = 6'o60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_sel,
    input  logic              line_valid,
    input  logic [LINE_W-1:0] line_data,
    output logic              busy,
    output logic [WORD_W-1:0] word_out,
    output logic              word_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              exec_start,
    output logic [ADDR_W-1:0] exec_addr,
    output logic              boot_err
);

    import tape_ldr_pkg::*;

    typedef struct packed {
        mode_e mode;
    } top_t;

    top_t q, d;
    cmd_e cmd;

    logic              take_char;
    logic              take_pack;
    logic [DATA_W-1:0] data_bits;
    logic              full_now;
    logic [WORD_W-1:0] full_word;
    logic              boot_start;
    logic              boot_full;
    logic              boot_finish;

    assign cmd        = cmd_e'(cmd_sel);
    assign boot_start = (q.mode == MODE_IDLE) && (cmd == CMD_BOOT);
    assign boot_full  = full_now && (q.mode == MODE_BOOT);

    tape_line_filter #(
        .LINE_W   (LINE_W),
        .DATA_W   (DATA_W),
        .MARK_BIT (MARK_BIT)
    ) u_filter (
        .line_valid (line_valid),
        .line_data  (line_data),
        .enable     (q.mode != MODE_IDLE),
        .pack_mode  ((q.mode == MODE_WORD) || (q.mode == MODE_BOOT)),
        .take_char  (take_char),
        .take_pack  (take_pack),
        .data_bits  (data_bits)
    );

    tape_word_shifter #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W),
        .LINE_W (LINE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_char (take_char),
        .take_pack (take_pack),
        .data_bits (data_bits),
        .char_bits (line_data),
        .full_now  (full_now),
        .full_word (full_word),
        .word_out  (word_out),
        .word_done (word_done)
    );

    tape_boot_seq #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W),
        .DEP_OP (DEP_OP),
        .JMP_OP (JMP_OP)
    ) u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (boot_start),
        .word_full  (boot_full),
        .word_bits  (full_word),
        .finish     (boot_finish),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .exec_start (exec_start),
        .exec_addr  (exec_addr),
        .boot_err   (boot_err)
    );

    always_comb begin
        d = q;
        unique case (q.mode)
            MODE_IDLE: begin
                unique case (cmd)
                    CMD_CHAR: d.mode = MODE_CHAR;
                    CMD_WORD: d.mode = MODE_WORD;
                    CMD_BOOT: d.mode = MODE_BOOT;
                    default:  d.mode = MODE_IDLE;
                endcase
            end
            MODE_CHAR: if (take_char)   d.mode = MODE_IDLE;
            MODE_WORD: if (full_now)    d.mode = MODE_IDLE;
            MODE_BOOT: if (boot_finish) d.mode = MODE_IDLE;
            default:                    d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{mode: MODE_IDLE};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.mode != MODE_IDLE);

endmodule

// File: rtl/tape_word_loader_chk.sv
module tape_word_loader_chk #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              word_done,
    input logic              mem_we,
    input logic              exec_start,
    input logic              boot_err,
    input logic [WORD_W-1:0] word_out,
    input logic [ADDR_W-1:0] exec_addr
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done); // R10

    AST_DONE_NEEDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(busy)); // R6

    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && rst_n && $past(rst_n)) |-> $stable(word_out)); // R6

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R7

    AST_WRITE_NOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && exec_start)); // R7

    AST_START_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> (!busy && word_done)); // R8

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (!exec_start && $stable(exec_addr))); // R8

    AST_ERR_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_err) |-> (!busy && !exec_start)); // R9

endmodule

bind tape_word_loader tape_word_loader_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .word_done  (word_done),
    .mem_we     (mem_we),
    .exec_start (exec_start),
    .boot_err   (boot_err),
    .word_out   (word_out),
    .exec_addr  (exec_addr)
);

// File: tb/tape_word_loader_test.sv
`timescale 1ns/1ps
module tape_word_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_sel = 2'd0;
    logic        line_valid = 1'b0;
    logic [7:0]  line_data = 8'd0;
    logic        busy;
    logic [35:0] word_out;
    logic        word_done;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        exec_start;
    logic [11:0] exec_addr;
    logic        boot_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tape_word_loader uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_sel    (cmd_sel),
        .line_valid (line_valid),
        .line_data  (line_data),
        .busy       (busy),
        .word_out   (word_out),
        .word_done  (word_done),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .exec_start (exec_start),
        .exec_addr  (exec_addr),
        .boot_err   (boot_err)
    );

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] c);
        @(negedge clk) cmd_sel = c;
        @(negedge clk) cmd_sel = 2'd0;
    endtask

    task automatic send_line(input logic [7:0] l);
        @(negedge clk) begin line_valid = 1'b1; line_data = l; end
        @(negedge clk) begin line_valid = 1'b0; line_data = 8'h00; end
    endtask

    // Six marked lines, high group first; optional unmarked junk lines and hole 7 set.
    task automatic send_word(input logic [35:0] w, input bit noise);
        for (int i = 0; i < 6; i++) begin
            if (noise && (i % 2 == 0)) send_line(8'b0111_1111);
            send_line({1'b1, noise, w[35 - 6*i -: 6]});
        end
    endtask

    task automatic t_reset;
        check_eq("R1 word_out", word_out, 0);
        check_eq("R1 word_done", word_done, 0);
        check_eq("R1 busy", busy, 0);
        check_eq("R1 mem_we", mem_we, 0);
        check_eq("R1 exec_start", exec_start, 0);
        check_eq("R1 boot_err", boot_err, 0);
    endtask

    task automatic t_char;
        send_cmd(2'd1);
        check_eq("R2 busy after cmd", busy, 1);
        send_line(8'h5A);
        check_eq("R2 word_out", word_out, 36'h5A);
        check_eq("R2 word_done", word_done, 1);
        check_eq("R2 busy low", busy, 0);
        @(negedge clk);
        check_eq("R2 done one cycle", word_done, 0);
        send_cmd(2'd1);
        send_line(8'hFF);
        check_eq("R2 all holes", word_out, 36'hFF);
    endtask

    task automatic t_word;
        logic [35:0] w;
        w = 36'o123456701234;
        send_cmd(2'd2);
        send_word(w, 1'b0);
        check_eq("R3 word_out", word_out, w);
        check_eq("R3 word_done", word_done, 1);
        check_eq("R3 busy low", busy, 0);
        @(negedge clk);
        check_eq("R3 done one cycle", word_done, 0);
        w = 36'o765432107654;
        send_cmd(2'd2);
        send_word(w, 1'b1);
        check_eq("R5 hole7 and R4 skip word", word_out, w);
    endtask

    task automatic t_skip;
        logic [35:0] w;
        w = 36'o010203040506;
        send_cmd(2'd2);
        for (int i = 0; i < 5; i++) send_line({2'b10, w[35 - 6*i -: 6]});
        send_line(8'b0011_1111);
        check_eq("R4 unmarked not counted done", word_done, 0);
        check_eq("R4 still busy", busy, 1);
        send_line({2'b10, w[5:0]});
        check_eq("R4 word after skip", word_out, w);
        check_eq("R4 done after sixth", word_done, 1);
    endtask

    task automatic t_ignore;
        logic [35:0] prev;
        prev = word_out;
        send_line(8'hC3);
        check_eq("R6 idle line no done", word_done, 0);
        check_eq("R6 idle line word held", word_out, prev);
        check_eq("R6 idle stays idle", busy, 0);
        send_cmd(2'd1);
        send_cmd(2'd2);
        send_line(8'h21);
        check_eq("R6 busy cmd ignored char kept", word_out, 36'h21);
        check_eq("R6 done", word_done, 1);
    endtask

    task automatic t_boot;
        logic [35:0] d1, d2;
        d1 = 36'o777000111222;
        d2 = 36'o000123000456;
        send_cmd(2'd3);
        send_word({6'o32, 18'd0, 12'o1234}, 1'b1);
        check_eq("R10 done on instruction", word_done, 1);
        check_eq("R7 no write on instruction", mem_we, 0);
        send_word(d1, 1'b0);
        check_eq("R7 mem_we", mem_we, 1);
        check_eq("R7 mem_addr", mem_addr, 12'o1234);
        check_eq("R7 mem_wdata", mem_wdata, d1);
        check_eq("R10 done on data", word_done, 1);
        @(negedge clk);
        check_eq("R7 we one cycle", mem_we, 0);
        check_eq("R7 still loading", busy, 1);
        send_word({6'o32, 18'o777777, 12'o0042}, 1'b0);
        send_word(d2, 1'b1);
        check_eq("R7 second write addr", mem_addr, 12'o0042);
        check_eq("R7 second write data", mem_wdata, d2);
        send_word({6'o60, 18'd0, 12'o4321}, 1'b0);
        check_eq("R8 exec_start", exec_start, 1);
        check_eq("R8 exec_addr", exec_addr, 12'o4321);
        check_eq("R8 busy low", busy, 0);
        check_eq("R8 no write", mem_we, 0);
        @(negedge clk);
        check_eq("R8 start one cycle", exec_start, 0);
    endtask

    task automatic t_boot_err;
        send_cmd(2'd3);
        send_word({6'o77, 18'd0, 12'o0100}, 1'b0);
        check_eq("R9 boot_err", boot_err, 1);
        check_eq("R9 busy low", busy, 0);
        check_eq("R9 no write", mem_we, 0);
        check_eq("R9 no start", exec_start, 0);
        send_word(36'o111111111111, 1'b0);
        check_eq("R9 load stopped no write", mem_we, 0);
        check_eq("R9 err held", boot_err, 1);
        send_cmd(2'd3);
        check_eq("R9 err cleared by new load", boot_err, 0);
        send_word({6'o60, 18'd0, 12'o0007}, 1'b0);
        check_eq("R9 recovered start addr", exec_addr, 12'o0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_char();
        t_word();
        t_skip();
        t_ignore();
        t_boot();
        t_boot_err();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule